// File: doc/BRIEF.md
# Configuration Space Window Decoder

This block sits in front of the register storage of an emulated bridge function and routes each configuration access to the region that owns it. There are four regions: the 64-byte standard header, an optional 8-byte subsystem-ID capability, an optional 60-byte PCIe capability, and the extended space from byte 0x100 upward. The block strips the region base from the address and hands the local offset to the external storage port of that region. Storage for the header and the PCIe capability lives outside the block. The extended space is a plain pass-through port. The subsystem-ID capability is produced inside the block from its strap inputs.

Capability placement is derived from two enable straps and two optional forced start offsets. From these the block computes where each capability starts. It also fills in the header capability pointer, the capability-list status bit, the capability IDs, the next pointers and the PCIe port-type field on the read path. Sub-dword writes become full-dword writes: the block merges the new bytes into the dword the region port currently returns. Read data is returned through a register one cycle after the request. Write strobes are issued combinationally in the request cycle.

Top module: `cfg_window_decoder`

## Requirements
- R1: An aligned address below 0x40 selects the header region. `hdr_off` equals the aligned address, and a write pulses `hdr_we` in the same cycle.
- R2: Header reads overlay two fields. Bits 7:0 of dword 0x34 return the capability pointer. Bit 20 of dword 0x04 reads 1 whenever the capability pointer is non-zero, and otherwise returns the stored bit.
- R3: With both forced starts at 0, an enabled subsystem-ID capability starts at 0x40. An enabled PCIe capability starts at 0x48 when the subsystem-ID capability is enabled, and at 0x40 otherwise. The capability pointer is the lowest enabled start, or 0 when none is enabled.
- R4: With only the PCIe start forced (value P), the subsystem-ID capability starts at 0x40 when P >= 0x48, and at P+60 otherwise.
- R5: With only the subsystem-ID start forced (value S), the PCIe capability starts at 0x40 when S >= 0x7C, and at S+8 otherwise.
- R6: Each capability's next pointer (bits 15:8 of its first dword) holds the start of the other enabled capability when that start is higher, and 0 otherwise.
- R7: The subsystem-ID capability reads {next, 0x0D} in bits 15:0 of its first dword. Its second dword reads {subsystem ID, subsystem vendor ID}, with the vendor ID in bits 15:0. A write to this capability pulses no strobe and changes nothing.
- R8: In the PCIe capability window (60 bytes), `pcie_off` is the address minus the start. The first dword reads ID 0x10 in bits 7:0, the next pointer in bits 15:8 and port type 4 in bits 23:20. All other bits come from `pcie_rdata`.
- R9: When PCIe is enabled, an aligned address at or above 0x100 goes to the extended port with `ext_off` equal to the address minus 0x100. When PCIe is disabled, such an address is unmapped.
- R10: An address in no enabled region reads 0, and a write to it pulses no strobe.
- R11: `req_size` encodes 0 = byte, 1 = halfword, 2 or 3 = dword. A read returns the selected dword shifted right by 8 times `req_addr[1:0]` and masked to 8, 16 or 32 bits.
- R12: A sub-dword write drives the full dword. The lanes covered by (0xFF or 0xFFFF) << (8 × `req_addr[1:0]`), truncated to 32 bits, take the shifted `req_wdata`. All other lanes keep the region port's current read value.
- R13: `rsp_valid` pulses exactly one cycle after a read request and never after a write. `rsp_rdata` is registered. Both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, right-aligned |
| ssid_en | input | 1 | Enable subsystem-ID capability |
| pcie_en | input | 1 | Enable PCIe capability and extended space |
| ssid_force | input | 8 | Forced subsystem-ID start, 0 = automatic |
| pcie_force | input | 8 | Forced PCIe start, 0 = automatic |
| ssid_vendor | input | 16 | Subsystem vendor ID |
| ssid_device | input | 16 | Subsystem ID |
| hdr_off | output | 6 | Header dword byte offset |
| hdr_rdata | input | 32 | Header storage read value at hdr_off |
| hdr_we | output | 1 | Header write strobe |
| hdr_wdata | output | 32 | Merged header write dword |
| pcie_off | output | 6 | PCIe capability byte offset |
| pcie_rdata | input | 32 | PCIe storage read value at pcie_off |
| pcie_we | output | 1 | PCIe write strobe |
| pcie_wdata | output | 32 | Merged PCIe write dword |
| ext_off | output | 12 | Extended-space byte offset |
| ext_rdata | input | 32 | Extended-space read value at ext_off |
| ext_we | output | 1 | Extended-space write strobe |
| ext_wdata | output | 32 | Merged extended-space write dword |

## Verification
Write strobes, offsets and merged write data are combinational in the request cycle. The bench drives each request on a falling edge and compares them 1 ns later, before the next rising edge commits them to its storage model. Read data and `rsp_valid` appear at the first rising edge after the request, so they are compared at the following falling edge. The idle cycle that follows is checked for `rsp_valid` low. Expected values come from a behavioural model of the placement rules and of the region storage, kept apart from the storage the design writes into.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_HDR  = 3'd1,
    RG_SSID = 3'd2,
    RG_PCIE = 3'd3,
    RG_EXT  = 3'd4
  } region_e;

  localparam logic [7:0] CAP_ID_SSID    = 8'h0D;
  localparam logic [7:0] CAP_ID_PCIE    = 8'h10;
  localparam logic [3:0] PORT_TYPE_ROOT = 4'h4;
  localparam int         OFF_STATUS     = 'h04;
  localparam int         OFF_CAPPTR     = 'h34;
  localparam int         CAPLIST_BIT    = 20;
endpackage

// File: rtl/cfgwin_layout.sv
module cfgwin_layout #(
  parameter int PTR_W      = 8,
  parameter int HDR_BYTES  = 64,
  parameter int SSID_BYTES = 8,
  parameter int PCIE_BYTES = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ssid_en,
  input  logic             pcie_en,
  input  logic [PTR_W-1:0] ssid_force,
  input  logic [PTR_W-1:0] pcie_force,
  output logic [PTR_W-1:0] ssid_at,
  output logic [PTR_W-1:0] pcie_at,
  output logic [PTR_W-1:0] cap_ptr,
  output logic [PTR_W-1:0] ssid_next,
  output logic [PTR_W-1:0] pcie_next
);
  localparam logic [PTR_W-1:0] FIRST     = PTR_W'(HDR_BYTES);
  localparam logic [PTR_W-1:0] SSID_LEN  = PTR_W'(SSID_BYTES);
  localparam logic [PTR_W-1:0] PCIE_LEN  = PTR_W'(PCIE_BYTES);
  localparam logic [PTR_W-1:0] SSID_FITS = PTR_W'(HDR_BYTES + SSID_BYTES);
  localparam logic [PTR_W-1:0] PCIE_FITS = PTR_W'(HDR_BYTES + PCIE_BYTES);

  logic [PTR_W-1:0] ssid_pos, pcie_pos;

  always_comb begin
    ssid_pos = ssid_force;
    pcie_pos = pcie_force;
    if (ssid_force == '0 && pcie_force == '0) begin
      ssid_pos = FIRST;
      pcie_pos = ssid_en ? FIRST + SSID_LEN : FIRST;
    end else if (ssid_force == '0) begin
      ssid_pos = (pcie_force >= SSID_FITS) ? FIRST : pcie_force + PCIE_LEN;
    end else if (pcie_force == '0) begin
      pcie_pos = (ssid_force >= PCIE_FITS) ? FIRST : ssid_force + SSID_LEN;
    end
  end

  assign ssid_at = ssid_en ? ssid_pos : '0;
  assign pcie_at = pcie_en ? pcie_pos : '0;

  always_comb begin
    if (ssid_en && pcie_en) cap_ptr = (ssid_at < pcie_at) ? ssid_at : pcie_at;
    else if (ssid_en)       cap_ptr = ssid_at;
    else if (pcie_en)       cap_ptr = pcie_at;
    else                    cap_ptr = '0;
  end

  assign ssid_next = (pcie_en && pcie_at > ssid_at) ? pcie_at : '0;
  assign pcie_next = (ssid_en && ssid_at > pcie_at) ? ssid_at : '0;

  // R6: with both capabilities present exactly one of them links onward
  p_chain_single_r6: assert property (@(posedge clk) disable iff (rst)
    (ssid_en && pcie_en) |-> ((ssid_next == '0) != (pcie_next == '0)));

  // R3: a non-zero pointer always names an enabled capability start
  p_capptr_names_cap_r3: assert property (@(posedge clk) disable iff (rst)
    (cap_ptr != '0) |-> ((ssid_en && cap_ptr == ssid_at) || (pcie_en && cap_ptr == pcie_at)));
endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PTR_W      = 8,
  parameter int HDR_BYTES  = 64,
  parameter int SSID_BYTES = 8,
  parameter int PCIE_BYTES = 60,
  parameter int EXT_BASE   = 256
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ssid_en,
  input  logic              pcie_en,
  input  logic [PTR_W-1:0]  ssid_at,
  input  logic [PTR_W-1:0]  pcie_at,
  output region_e           region,
  output logic [ADDR_W-1:0] local_off
);
  logic [ADDR_W-1:0] s_lo, s_hi, p_lo, p_hi;
  logic in_hdr, in_ssid, in_pcie, in_ext;

  assign s_lo = ADDR_W'(ssid_at);
  assign s_hi = ADDR_W'(ssid_at) + ADDR_W'(SSID_BYTES);
  assign p_lo = ADDR_W'(pcie_at);
  assign p_hi = ADDR_W'(pcie_at) + ADDR_W'(PCIE_BYTES);

  assign in_hdr  = addr < ADDR_W'(HDR_BYTES);
  assign in_ssid = ssid_en && addr >= s_lo && addr < s_hi;
  assign in_pcie = pcie_en && addr >= p_lo && addr < p_hi;
  assign in_ext  = pcie_en && addr >= ADDR_W'(EXT_BASE);

  always_comb begin
    region    = RG_NONE;
    local_off = '0;
    if (in_hdr) begin
      region    = RG_HDR;
      local_off = addr;
    end else if (in_ssid) begin
      region    = RG_SSID;
      local_off = addr - s_lo;
    end else if (in_pcie) begin
      region    = RG_PCIE;
      local_off = addr - p_lo;
    end else if (in_ext) begin
      region    = RG_EXT;
      local_off = addr - ADDR_W'(EXT_BASE);
    end
  end
endmodule

// File: rtl/cfgwin_lanes.sv
module cfgwin_lanes #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 2
) (
  input  logic [SEL_W-1:0]  byte_sel,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] old,
  input  logic [DATA_W-1:0] rd_dword,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] rd_lane
);
  logic [SEL_W+2:0]  shift;
  logic [DATA_W-1:0] width_mask, wmask;

  assign shift = {byte_sel, 3'b000};

  always_comb begin
    case (size)
      2'd0:    width_mask = DATA_W'(8'hFF);
      2'd1:    width_mask = DATA_W'(16'hFFFF);
      default: width_mask = '1;
    endcase
  end

  assign wmask   = width_mask << shift;
  assign merged  = (old & ~wmask) | ((wdata << shift) & wmask);
  assign rd_lane = (rd_dword >> shift) & width_mask;
endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int PTR_W      = 8,
  parameter int ID_W       = 16,
  parameter int HDR_BYTES  = 64,
  parameter int SSID_BYTES = 8,
  parameter int PCIE_BYTES = 60,
  parameter int EXT_BASE   = 256,
  localparam int HDR_OFF_W  = $clog2(HDR_BYTES),
  localparam int PCIE_OFF_W = $clog2(PCIE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [1:0]            req_size,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  input  logic                  ssid_en,
  input  logic                  pcie_en,
  input  logic [PTR_W-1:0]      ssid_force,
  input  logic [PTR_W-1:0]      pcie_force,
  input  logic [ID_W-1:0]       ssid_vendor,
  input  logic [ID_W-1:0]       ssid_device,
  output logic [HDR_OFF_W-1:0]  hdr_off,
  input  logic [DATA_W-1:0]     hdr_rdata,
  output logic                  hdr_we,
  output logic [DATA_W-1:0]     hdr_wdata,
  output logic [PCIE_OFF_W-1:0] pcie_off,
  input  logic [DATA_W-1:0]     pcie_rdata,
  output logic                  pcie_we,
  output logic [DATA_W-1:0]     pcie_wdata,
  output logic [ADDR_W-1:0]     ext_off,
  input  logic [DATA_W-1:0]     ext_rdata,
  output logic                  ext_we,
  output logic [DATA_W-1:0]     ext_wdata
);
  logic [PTR_W-1:0]  ssid_at, pcie_at, cap_ptr, ssid_next, pcie_next;
  logic [ADDR_W-1:0] aligned, local_off;
  region_e           region;
  logic [DATA_W-1:0] old_raw, rd_dword, merged, rd_lane;
  logic              wr_req, rd_req;

  cfgwin_layout #(
    .PTR_W(PTR_W), .HDR_BYTES(HDR_BYTES), .SSID_BYTES(SSID_BYTES), .PCIE_BYTES(PCIE_BYTES)
  ) u_layout (
    .clk(clk), .rst(rst), .ssid_en(ssid_en), .pcie_en(pcie_en),
    .ssid_force(ssid_force), .pcie_force(pcie_force),
    .ssid_at(ssid_at), .pcie_at(pcie_at), .cap_ptr(cap_ptr),
    .ssid_next(ssid_next), .pcie_next(pcie_next)
  );

  assign aligned = {req_addr[ADDR_W-1:2], 2'b00};

  cfgwin_decode #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .HDR_BYTES(HDR_BYTES), .SSID_BYTES(SSID_BYTES),
    .PCIE_BYTES(PCIE_BYTES), .EXT_BASE(EXT_BASE)
  ) u_decode (
    .addr(aligned), .ssid_en(ssid_en), .pcie_en(pcie_en),
    .ssid_at(ssid_at), .pcie_at(pcie_at), .region(region), .local_off(local_off)
  );

  // Read path: raw port value for the merge, overlaid value for the return
  always_comb begin
    old_raw  = '0;
    rd_dword = '0;
    case (region)
      RG_HDR: begin
        old_raw  = hdr_rdata;
        rd_dword = hdr_rdata;
        if (local_off == ADDR_W'(OFF_CAPPTR)) rd_dword[PTR_W-1:0] = cap_ptr;
        if (local_off == ADDR_W'(OFF_STATUS) && cap_ptr != '0) rd_dword[CAPLIST_BIT] = 1'b1;
      end
      RG_SSID: begin
        rd_dword = (local_off == '0) ? DATA_W'({ssid_next, CAP_ID_SSID})
                                     : DATA_W'({ssid_device, ssid_vendor});
      end
      RG_PCIE: begin
        old_raw  = pcie_rdata;
        rd_dword = pcie_rdata;
        if (local_off == '0) begin
          rd_dword[7:0]   = CAP_ID_PCIE;
          rd_dword[15:8]  = pcie_next;
          rd_dword[23:20] = PORT_TYPE_ROOT;
        end
      end
      RG_EXT: begin
        old_raw  = ext_rdata;
        rd_dword = ext_rdata;
      end
      default: begin
        old_raw  = '0;
        rd_dword = '0;
      end
    endcase
  end

  cfgwin_lanes #(.DATA_W(DATA_W), .SEL_W(2)) u_lanes (
    .byte_sel(req_addr[1:0]), .size(req_size), .wdata(req_wdata),
    .old(old_raw), .rd_dword(rd_dword), .merged(merged), .rd_lane(rd_lane)
  );

  assign wr_req = req_valid && req_write;
  assign rd_req = req_valid && !req_write;

  assign hdr_off    = local_off[HDR_OFF_W-1:0];
  assign pcie_off   = local_off[PCIE_OFF_W-1:0];
  assign ext_off    = local_off;
  assign hdr_we     = wr_req && region == RG_HDR;
  assign pcie_we    = wr_req && region == RG_PCIE;
  assign ext_we     = wr_req && region == RG_EXT;
  assign hdr_wdata  = merged;
  assign pcie_wdata = merged;
  assign ext_wdata  = merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_lane;
    end
  end

  // R13: read data returns one cycle after a read, nothing after anything else
  p_rsp_latency_r13: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);
  p_no_spurious_rsp_r13: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R1: header strobe only for addresses inside the header
  p_hdr_range_r1: assert property (@(posedge clk) disable iff (rst)
    hdr_we |-> (req_addr < ADDR_W'(HDR_BYTES)));

  // R9: extended strobe only with PCIe enabled and at or above the base
  p_ext_gate_r9: assert property (@(posedge clk) disable iff (rst)
    ext_we |-> (pcie_en && req_addr >= ADDR_W'(EXT_BASE)));

  // R10: at most one region strobe per access
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hdr_we, pcie_we, ext_we}));

  // R12: a byte write leaves the other three lanes at the stored value
  p_merge_keeps_r12: assert property (@(posedge clk) disable iff (rst)
    (hdr_we && req_size == 2'd0) |->
      (((hdr_wdata ^ hdr_rdata) & ~(DATA_W'(8'hFF) << {req_addr[1:0], 3'b000})) == '0));
endmodule

// File: tb/test_cfg_window_decoder.sv
module test_cfg_window_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        ssid_en = 1'b0, pcie_en = 1'b0;
  logic [7:0]  ssid_force = '0, pcie_force = '0;
  logic [15:0] ssid_vendor = 16'h5E11, ssid_device = 16'hC0DE;
  logic [5:0]  hdr_off, pcie_off;
  logic [11:0] ext_off;
  logic [31:0] hdr_rdata, pcie_rdata, ext_rdata;
  logic        hdr_we, pcie_we, ext_we;
  logic [31:0] hdr_wdata, pcie_wdata, ext_wdata;

  int compared = 0, mismatched = 0;

  // storage written by the design
  logic [31:0] hdr_store [16];
  logic [31:0] pcie_store[15];
  // model copy, updated from expected writes only
  logic [31:0] m_hdr [16];
  logic [31:0] m_pcie[15];
  int ss, ps, cp, sn, pn;

  always #4 clk = ~clk;

  cfg_window_decoder i_cfg_window_decoder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ssid_en(ssid_en), .pcie_en(pcie_en), .ssid_force(ssid_force), .pcie_force(pcie_force),
    .ssid_vendor(ssid_vendor), .ssid_device(ssid_device),
    .hdr_off(hdr_off), .hdr_rdata(hdr_rdata), .hdr_we(hdr_we), .hdr_wdata(hdr_wdata),
    .pcie_off(pcie_off), .pcie_rdata(pcie_rdata), .pcie_we(pcie_we), .pcie_wdata(pcie_wdata),
    .ext_off(ext_off), .ext_rdata(ext_rdata), .ext_we(ext_we), .ext_wdata(ext_wdata)
  );

  assign hdr_rdata  = hdr_store[hdr_off[5:2]];
  assign pcie_rdata = (pcie_off[5:2] < 4'd15) ? pcie_store[pcie_off[5:2]] : 32'h0;
  assign ext_rdata  = 32'hE000_0000 | {20'h0, ext_off};

  always @(posedge clk) begin
    if (hdr_we) hdr_store[hdr_off[5:2]] <= hdr_wdata;
    if (pcie_we && pcie_off[5:2] < 4'd15) pcie_store[pcie_off[5:2]] <= pcie_wdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic model_layout();
    int sf = int'(ssid_force);
    int pf = int'(pcie_force);
    if (sf == 0 && pf == 0) begin
      ss = 64; ps = ssid_en ? 72 : 64;
    end else if (sf == 0) begin
      ps = pf; ss = (pf - 64 >= 8) ? 64 : pf + 60;
    end else if (pf == 0) begin
      ss = sf; ps = (sf - 64 >= 60) ? 64 : sf + 8;
    end else begin
      ss = sf; ps = pf;
    end
    if (!ssid_en) ss = 0;
    if (!pcie_en) ps = 0;
    if (ssid_en && pcie_en) cp = (ss < ps) ? ss : ps;
    else if (ssid_en) cp = ss;
    else if (pcie_en) cp = ps;
    else cp = 0;
    sn = (pcie_en && ps > ss) ? ps : 0;
    pn = (ssid_en && ss > ps) ? ss : 0;
  endtask

  // 1 header, 2 subsystem-ID, 3 PCIe, 4 extended, 0 unmapped
  function automatic int model_region(int a);
    if (a < 64) return 1;
    if (ssid_en && a >= ss && a < ss + 8) return 2;
    if (pcie_en && a >= ps && a < ps + 60) return 3;
    if (pcie_en && a >= 256) return 4;
    return 0;
  endfunction

  function automatic logic [31:0] model_dword(int a);
    logic [31:0] d;
    case (model_region(a))
      1: begin
        d = m_hdr[a / 4];
        if (a == 52) d[7:0] = 8'(cp);
        if (a == 4 && cp != 0) d[20] = 1'b1;
      end
      2: d = (a == ss) ? {16'h0, 8'(sn), 8'h0D} : {ssid_device, ssid_vendor};
      3: begin
        d = m_pcie[(a - ps) / 4];
        if (a == ps) begin d[7:0] = 8'h10; d[15:8] = 8'(pn); d[23:20] = 4'h4; end
      end
      4: d = 32'hE000_0000 | 32'(a - 256);
      default: d = 32'h0;
    endcase
    return d;
  endfunction

  function automatic logic [31:0] size_mask(int size);
    if (size == 0) return 32'h0000_00FF;
    if (size == 1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic access(input bit wr, input int addr, input int size,
                        input logic [31:0] wd, input string tag);
    int a = addr & ~3;
    int sh = (addr & 3) * 8;
    int rg;
    logic [31:0] msk, old, nw, exp_rd;
    @(negedge clk);
    chk({tag, " R13 idle rsp_valid"}, 32'(rsp_valid), 32'h0);
    req_valid = 1'b1; req_write = wr; req_addr = 12'(addr);
    req_size = 2'(size); req_wdata = wd;
    #1;
    model_layout();
    rg = model_region(a);
    exp_rd = (model_dword(a) >> sh) & size_mask(size);
    msk = size_mask(size) << sh;
    chk({tag, " hdr_we"},  32'(hdr_we),  32'(wr && rg == 1));
    chk({tag, " pcie_we"}, 32'(pcie_we), 32'(wr && rg == 3));
    chk({tag, " ext_we"},  32'(ext_we),  32'(wr && rg == 4));
    if (wr && rg == 1) begin
      old = m_hdr[a / 4];
      nw = (old & ~msk) | ((wd << sh) & msk);
      chk({tag, " hdr_off"}, 32'(hdr_off), 32'(a));
      chk({tag, " hdr_wdata"}, hdr_wdata, nw);
      m_hdr[a / 4] = nw;
    end else if (wr && rg == 3) begin
      old = m_pcie[(a - ps) / 4];
      nw = (old & ~msk) | ((wd << sh) & msk);
      chk({tag, " pcie_off"}, 32'(pcie_off), 32'(a - ps));
      chk({tag, " pcie_wdata"}, pcie_wdata, nw);
      m_pcie[(a - ps) / 4] = nw;
    end else if (wr && rg == 4) begin
      old = 32'hE000_0000 | 32'(a - 256);
      nw = (old & ~msk) | ((wd << sh) & msk);
      chk({tag, " ext_off"}, 32'(ext_off), 32'(a - 256));
      chk({tag, " ext_wdata"}, ext_wdata, nw);
    end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk({tag, " R13 rsp_valid"}, 32'(rsp_valid), 32'(!wr));
    if (!wr) chk({tag, " rsp_rdata"}, rsp_rdata, exp_rd);
  endtask

  task automatic rd(input int addr, input int size, input string tag);
    access(1'b0, addr, size, 32'h0, tag);
  endtask

  task automatic wr(input int addr, input int size, input logic [31:0] d, input string tag);
    access(1'b1, addr, size, d, tag);
  endtask

  task automatic straps(input bit se, input bit pe, input int sf, input int pf);
    @(negedge clk);
    ssid_en = se; pcie_en = pe; ssid_force = 8'(sf); pcie_force = 8'(pf);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      hdr_store[i] = 32'h0B00_0000 | 32'(i << 8) | 32'(i);
      m_hdr[i] = hdr_store[i];
    end
    for (int i = 0; i < 15; i++) begin
      pcie_store[i] = 32'hC300_0000 | (32'(i) * 32'h0001_0101);
      m_pcie[i] = pcie_store[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R13 reset rsp_valid", 32'(rsp_valid), 32'h0);
    chk("R13 reset rsp_rdata", rsp_rdata, 32'h0);

    // both capabilities, automatic placement
    straps(1, 1, 0, 0);
    rd('h00, 2, "R1 header dword 0");
    rd('h34, 2, "R2 capability pointer");
    rd('h04, 2, "R2 cap-list status bit");
    rd('h34, 2, "R3 auto pointer");
    rd('h40, 2, "R7 ssid dword 0 with R6 next");
    rd('h44, 2, "R7 ssid ids");
    rd('h48, 2, "R8 pcie dword 0");
    rd('h50, 2, "R8 pcie body");
    rd('h80, 2, "R8 pcie last dword");
    rd('h84, 2, "R10 past pcie end");
    rd('h100, 2, "R9 ext base");
    rd('h3FC, 2, "R9 ext high");
    rd('h41, 0, "R11 byte read next pointer");
    rd('h46, 1, "R11 halfword read device id");
    rd('h4B, 0, "R11 byte read top lane");
    wr('h10, 2, 32'h1234_5678, "R1 header dword write");
    rd('h10, 2, "R1 header readback");
    wr('h19, 0, 32'h0000_00AB, "R12 byte write lane 1");
    rd('h18, 2, "R12 byte merge readback");
    wr('h1E, 1, 32'h0000_BEEF, "R12 halfword write lane 2");
    rd('h1C, 2, "R12 halfword merge readback");
    wr('h1F, 1, 32'h0000_77CC, "R12 halfword at lane 3 truncated");
    rd('h1C, 2, "R12 truncated readback");
    wr('h44, 2, 32'hFFFF_FFFF, "R7 ssid write ignored");
    rd('h44, 2, "R7 ssid unchanged");
    wr('h84, 2, 32'hFFFF_FFFF, "R10 unmapped write");
    wr('h4D, 0, 32'h0000_0099, "R12 pcie byte write");
    rd('h4C, 2, "R12 pcie readback");
    wr('h48, 2, 32'h00FF_FFFF, "R8 pcie dword 0 write");
    rd('h48, 2, "R8 overlay after write");
    wr('h10A, 1, 32'h0000_1357, "R9 ext halfword write");

    // subsystem-ID only
    straps(1, 0, 0, 0);
    rd('h34, 2, "R3 ssid only pointer");
    rd('h40, 2, "R6 ssid next zero");
    rd('h48, 2, "R10 pcie disabled");
    rd('h100, 2, "R9 ext disabled");
    wr('h100, 2, 32'h1, "R9 ext write disabled");

    // PCIe only
    straps(0, 1, 0, 0);
    rd('h34, 2, "R3 pcie only pointer");
    rd('h04, 2, "R2 cap-list with pcie only");
    rd('h40, 2, "R8 pcie at header end");
    rd('h7C, 2, "R8 pcie last");
    rd('h80, 2, "R10 after pcie");

    // PCIe forced, room before it
    straps(1, 1, 0, 'h60);
    rd('h34, 2, "R4 pointer");
    rd('h40, 2, "R4 ssid at header end");
    rd('h60, 2, "R4 forced pcie");
    rd('h48, 2, "R10 gap");

    // PCIe forced, no room before it
    straps(1, 1, 0, 'h44);
    rd('h34, 2, "R4 pointer tight");
    rd('h44, 2, "R4 pcie dword 0");
    rd('h80, 2, "R4 ssid after pcie");
    rd('h40, 2, "R10 hole before pcie");

    // subsystem-ID forced far up
    straps(1, 1, 'hA0, 0);
    rd('h34, 2, "R5 pointer");
    rd('h40, 2, "R5 pcie at header end");
    rd('hA0, 2, "R5 forced ssid");

    // subsystem-ID forced low
    straps(1, 1, 'h50, 0);
    rd('h34, 2, "R5 pointer low");
    rd('h50, 2, "R5 ssid dword 0");
    rd('h58, 2, "R5 pcie after ssid");

    // both forced
    straps(1, 1, 'h90, 'h40);
    rd('h40, 2, "R6 pcie links to ssid");
    rd('h90, 2, "R6 ssid ends chain");

    // nothing enabled
    straps(0, 0, 0, 0);
    rd('h04, 2, "R2 no cap-list bit");
    rd('h34, 2, "R2 zero pointer");
    rd('h40, 2, "R10 nothing above header");
    rd('h100, 2, "R9 no ext");

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule